// File: doc/BRIEF.md
# Binary Sobel Edge Merge Unit

This unit finds edges in a 1-bit image and stamps them onto the matching 8-bit grayscale image. In each cycle it takes a group of four neighbouring pixels from one image row, along with the binary rows directly above and below. Each binary row is given as six bits: the four pixels of the group plus one neighbour column on each side. The unit also takes the four original 8-bit pixels of the middle row, packed into one 32-bit word.

For every lane the unit works out a horizontal and a vertical Sobel response over the 3x3 binary window. Each response is a 4-bit two's-complement value. A lane is background when both responses are zero, which is an 8-input NOR of their bits. The merge ANDs each original pixel with its replicated background flag, so no multiplier is needed. Pixels on an edge become 0 and all other pixels pass through unchanged.

Four flags tell the unit when a group lies on the image border. Neighbours outside the image are then read as 0. Results appear two cycles after the input, together with a valid strobe.

Top module: `sobel_merge_top`

## Requirements
- R1: A group presented with `inValid` high in clock cycle n appears on `pixOut`, with `outValid` high, after the clock edge of cycle n+2. `outValid` is low at every other time and is not yet high after the edge of cycle n+1.
- R2: The horizontal response is (right-column sum) minus (left-column sum). The vertical response is (lower-row sum) minus (upper-row sum). Each sum weights the middle element by 2 and the outer elements by 1. Each response lies in [-4,+4].
- R3: Lane k (k=0..3) uses `pixIn[8k+7:8k]` and places its result at `pixOut[8k+7:8k]`. In each row vector, bit k+1 is the pixel of lane k, bit 0 is the column to the left of lane 0, and bit 5 is the column to the right of lane 3.
- R4: When both responses of a lane are zero, the lane's original pixel passes to the output unchanged.
- R5: When either response of a lane is non-zero, the lane's output pixel is 0.
- R6: `topEdge` makes the unit treat the whole upper row as 0. `bottomEdge` does the same for the lower row.
- R7: `firstGroup` makes the unit treat bit 0 of all three rows as 0. `lastGroup` does the same for bit 5.
- R8: While no new result is delivered, `pixOut` holds its last value, whatever the inputs do.
- R9: After reset, `outValid` is 0 and `pixOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The input group is valid this cycle |
| topEdge | input | 1 | The group is on the first image row |
| bottomEdge | input | 1 | The group is on the last image row |
| firstGroup | input | 1 | The group is the leftmost in its row |
| lastGroup | input | 1 | The group is the rightmost in its row |
| rowAbove | input | 6 | Binary row above, with side neighbours |
| rowMid | input | 6 | Binary middle row, with side neighbours |
| rowBelow | input | 6 | Binary row below, with side neighbours |
| pixIn | input | 32 | Four original 8-bit middle-row pixels |
| outValid | output | 1 | `pixOut` carries a new result |
| pixOut | output | 32 | Four merged 8-bit pixels |

## Verification
The input patterns are chosen so that each one exposes a different class of fault:
- **Uniform windows (all zero and all one):** both must pass every pixel unchanged. This separates a true zero-gradient test from a design that flags any set bit.
- **Vertical step and horizontal step:** each excites only one of the two kernels, so a missing or swapped kernel shows up.
- **Lone centre bit:** it must leave its own lane untouched while blanking both neighbouring lanes. This pins down the bit-to-lane mapping and the zero centre weight.
- **Border flags on an all-ones window:** each flag must turn a background result into edges in exactly the lanes it touches.
- **Back-to-back stream, then idle inputs:** checks the two-cycle latency and that the output holds between results.

// File: rtl/sobel_merge_pkg.sv
package sobel_merge_pkg;

  // strobes from the valid pipeline to the datapath
  typedef struct packed {
    logic loadSobel;
    logic loadMerge;
  } ctrlStrobes_t;

  // weighted column/row sum a + 2b + c of three binary pixels, range 0..4
  function automatic logic [2:0] weightSum(input logic a, input logic b, input logic c);
    return {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c};
  endfunction

endpackage

// File: rtl/sobel_merge_ctrl.sv
module sobel_merge_ctrl
  import sobel_merge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic vldS1;
  logic vldS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldS1 <= 1'b0;
      vldS2 <= 1'b0;
    end else begin
      vldS1 <= inValid;
      vldS2 <= vldS1;
    end
  end

  always_comb begin
    strobes.loadSobel = inValid;
    strobes.loadMerge = vldS1;
  end

  assign outValid = vldS2;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid); // R1

endmodule

// File: rtl/sobel_merge_dp.sv
module sobel_merge_dp
  import sobel_merge_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIXW  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic                    topEdge,
  input  logic                    bottomEdge,
  input  logic                    firstGroup,
  input  logic                    lastGroup,
  input  logic [LANES+1:0]        rowAbove,
  input  logic [LANES+1:0]        rowMid,
  input  logic [LANES+1:0]        rowBelow,
  input  logic [LANES*PIXW-1:0]   pixIn,
  output logic [LANES*PIXW-1:0]   pixOut
);

  localparam int ROWW  = LANES + 2;
  localparam int RESPW = 4;
  localparam int WORDW = LANES * PIXW;

  logic [ROWW-1:0] upM, midM, dnM;
  logic [ROWW-1:0] sideMask;

  // border masking: columns outside the image read as zero
  always_comb begin
    sideMask           = '1;
    sideMask[0]        = ~firstGroup;
    sideMask[ROWW-1]   = ~lastGroup;
    upM  = (topEdge    ? '0 : rowAbove) & sideMask;
    midM = rowMid & sideMask;
    dnM  = (bottomEdge ? '0 : rowBelow) & sideMask;
  end

  logic [LANES-1:0][RESPW-1:0] gxNext, gyNext;
  logic [LANES-1:0][RESPW-1:0] gxR, gyR;
  logic [WORDW-1:0]            pixR;
  logic [WORDW-1:0]            mergeNext;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [2:0] colL, colR, rowU, rowD;
    logic       bgFlag;

    always_comb begin
      colL = weightSum(upM[k],   midM[k],   dnM[k]);
      colR = weightSum(upM[k+2], midM[k+2], dnM[k+2]);
      rowU = weightSum(upM[k],   upM[k+1],  upM[k+2]);
      rowD = weightSum(dnM[k],   dnM[k+1],  dnM[k+2]);
      gxNext[k] = {1'b0, colR} - {1'b0, colL};
      gyNext[k] = {1'b0, rowD} - {1'b0, rowU};
      // inverse binarisation: NOR over all response bits
      bgFlag = ~|{gxR[k], gyR[k]};
      mergeNext[k*PIXW +: PIXW] = pixR[k*PIXW +: PIXW] & {PIXW{bgFlag}};
    end

    AST_GX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      ($signed(gxR[k]) <= 4'sd4) && ($signed(gxR[k]) >= -4'sd4)); // R2
    AST_GY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      ($signed(gyR[k]) <= 4'sd4) && ($signed(gyR[k]) >= -4'sd4)); // R2
    AST_MERGE_PASS_OR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      strobes.loadMerge |=> (pixOut[k*PIXW +: PIXW] == '0) ||
                            (pixOut[k*PIXW +: PIXW] == $past(pixR[k*PIXW +: PIXW]))); // R5
  end

  // stage 1: Sobel responses and delayed original pixels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gxR  <= '0;
      gyR  <= '0;
      pixR <= '0;
    end else if (strobes.loadSobel) begin
      gxR  <= gxNext;
      gyR  <= gyNext;
      pixR <= pixIn;
    end
  end

  // stage 2: merged output word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut <= '0;
    end else if (strobes.loadMerge) begin
      pixOut <= mergeNext;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadMerge |=> $stable(pixOut)); // R8

endmodule

// File: rtl/sobel_merge_top.sv
module sobel_merge_top
  import sobel_merge_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIXW  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  topEdge,
  input  logic                  bottomEdge,
  input  logic                  firstGroup,
  input  logic                  lastGroup,
  input  logic [LANES+1:0]      rowAbove,
  input  logic [LANES+1:0]      rowMid,
  input  logic [LANES+1:0]      rowBelow,
  input  logic [LANES*PIXW-1:0] pixIn,
  output logic                  outValid,
  output logic [LANES*PIXW-1:0] pixOut
);

  ctrlStrobes_t strobes;

  sobel_merge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  sobel_merge_dp #(.LANES(LANES), .PIXW(PIXW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .topEdge    (topEdge),
    .bottomEdge (bottomEdge),
    .firstGroup (firstGroup),
    .lastGroup  (lastGroup),
    .rowAbove   (rowAbove),
    .rowMid     (rowMid),
    .rowBelow   (rowBelow),
    .pixIn      (pixIn),
    .pixOut     (pixOut)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid); // R9

endmodule

// File: tb/sim_sobel_merge_top.sv
`timescale 1ns/1ps
module sim_sobel_merge_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        topEdge = 1'b0, bottomEdge = 1'b0, firstGroup = 1'b0, lastGroup = 1'b0;
  logic [5:0]  rowAbove = '0, rowMid = '0, rowBelow = '0;
  logic [31:0] pixIn = '0;
  logic        outValid;
  logic [31:0] pixOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sobel_merge_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .topEdge(topEdge), .bottomEdge(bottomEdge),
    .firstGroup(firstGroup), .lastGroup(lastGroup),
    .rowAbove(rowAbove), .rowMid(rowMid), .rowBelow(rowBelow),
    .pixIn(pixIn), .outValid(outValid), .pixOut(pixOut)
  );

  localparam logic [31:0] PX = 32'hC4_93_5A_E7;

  // expected merge computed from the requirement text
  function automatic logic [31:0] model(input logic [5:0] t, input logic [5:0] m,
                                        input logic [5:0] b, input logic [3:0] fl,
                                        input logic [31:0] p);
    logic [5:0] tt, mm, bb;
    logic [31:0] r;
    int gx, gy;
    tt = fl[3] ? 6'd0 : t;
    bb = fl[2] ? 6'd0 : b;
    mm = m;
    if (fl[1]) begin tt[0] = 0; mm[0] = 0; bb[0] = 0; end
    if (fl[0]) begin tt[5] = 0; mm[5] = 0; bb[5] = 0; end
    r = '0;
    for (int k = 0; k < 4; k++) begin
      gx = (int'(tt[k+2]) + 2*int'(mm[k+2]) + int'(bb[k+2])) -
           (int'(tt[k])   + 2*int'(mm[k])   + int'(bb[k]));
      gy = (int'(bb[k]) + 2*int'(bb[k+1]) + int'(bb[k+2])) -
           (int'(tt[k]) + 2*int'(tt[k+1]) + int'(tt[k+2]));
      r[8*k +: 8] = (gx == 0 && gy == 0) ? p[8*k +: 8] : 8'h00;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] t, input logic [5:0] m, input logic [5:0] b,
                       input logic [3:0] fl, input logic [31:0] p);
    rowAbove = t; rowMid = m; rowBelow = b;
    {topEdge, bottomEdge, firstGroup, lastGroup} = fl;
    pixIn = p;
  endtask

  // one group, checking latency and result
  task automatic single(input string req, input logic [5:0] t, input logic [5:0] m,
                        input logic [5:0] b, input logic [3:0] fl, input logic [31:0] p);
    @(negedge clk);
    drive(t, m, b, fl, p);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R1 early valid"}, {31'd0, outValid}, 32'd0);
    @(negedge clk);
    check({req, " R1 valid"}, {31'd0, outValid}, 32'd1);
    check(req, pixOut, model(t, m, b, fl, p));
  endtask

  task automatic testReset;
    check("R9 valid after reset", {31'd0, outValid}, 32'd0);
    check("R9 data after reset", pixOut, 32'd0);
  endtask

  task automatic testPatterns;
    single("R4 all zero", 6'b000000, 6'b000000, 6'b000000, 4'b0000, PX);
    check("R4 zero passes", pixOut, PX);
    single("R4 all one", 6'b111111, 6'b111111, 6'b111111, 4'b0000, PX);
    check("R4 ones pass", pixOut, PX);
    single("R2 R5 vertical step", 6'b000111, 6'b000111, 6'b000111, 4'b0000, PX);
    single("R2 R5 horizontal step", 6'b111111, 6'b000000, 6'b000000, 4'b0000, PX);
    single("R3 lone centre", 6'b000000, 6'b000100, 6'b000000, 4'b0000, PX);
    check("R3 lone centre lanes", pixOut, 32'hC4_00_5A_00);
    single("R2 diagonal", 6'b000001, 6'b000010, 6'b000100, 4'b0000, 32'h11_22_33_44);
  endtask

  task automatic testBorders;
    single("R6 top edge", 6'b111111, 6'b111111, 6'b111111, 4'b1000, PX);
    check("R6 top all edge", pixOut, 32'd0);
    single("R6 bottom edge", 6'b111111, 6'b111111, 6'b111111, 4'b0100, PX);
    single("R7 first group", 6'b111111, 6'b111111, 6'b111111, 4'b0010, PX);
    check("R7 lane0 only", pixOut, 32'hC4_93_5A_00);
    single("R7 last group", 6'b111111, 6'b111111, 6'b111111, 4'b0001, PX);
    check("R7 lane3 only", pixOut, 32'h00_93_5A_E7);
  endtask

  task automatic testStream;
    logic [5:0]  ts [3];
    logic [5:0]  ms [3];
    logic [31:0] ps [3];
    ts[0] = 6'b000111; ms[0] = 6'b000111; ps[0] = 32'hA1A2A3A4;
    ts[1] = 6'b111111; ms[1] = 6'b111111; ps[1] = 32'hB1B2B3B4;
    ts[2] = 6'b001000; ms[2] = 6'b010000; ps[2] = 32'hC1C2C3C4;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (i < 3) begin
        drive(ts[i], ms[i], ts[i], 4'b0000, ps[i]);
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
      if (i >= 2) begin
        check("R1 stream valid", {31'd0, outValid}, 32'd1);
        check("R1 stream data", pixOut, model(ts[i-2], ms[i-2], ts[i-2], 4'b0000, ps[i-2]));
      end
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic testHold;
    logic [31:0] last;
    single("R8 setup", 6'b000000, 6'b000000, 6'b000000, 4'b0000, 32'h5566_7788);
    last = pixOut;
    for (int i = 0; i < 4; i++) begin
      drive(6'b101010, 6'b010101, 6'b110011, 4'b1111, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R8 hold data", pixOut, last);
      check("R8 hold valid low", {31'd0, outValid}, 32'd0);
    end
  endtask

  initial begin
    #20000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPatterns();
    testBorders();
    testStream();
    testHold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule